// File: doc/BRIEF.md
# Integer Execute ALU with Overflow Trap

A purely combinational execute unit for a 32-bit load-store integer core. It takes two register operands, a shift-amount field and a six-bit function code. It returns a result word, a qualifier that says whether the destination register may be written, and a flag that requests an arithmetic exception.

Addition and subtraction each come in two forms. The trapping form flags signed overflow and blocks the register write. The wrapping form ignores overflow. The unit also provides the four bitwise logic operations, signed and unsigned less-than compares, and left, logical-right and arithmetic-right shifts. Each shift takes its amount either from the instruction field or from the low bits of the first operand.

Operand selection, immediate extension, the register file and exception dispatch belong to the surrounding pipeline. This unit only produces the flag and the write qualifier.

Top module: `exec_alu`

## Requirements
- R1: Function 0x20 (trapping add) and 0x21 (wrapping add) drive result_o with a_i + b_i modulo 2^32.
- R2: For 0x20 and 0x22 (trapping subtract), signed overflow sets ovf_o=1 and wr_en_o=0. Without overflow they give ovf_o=0 and wr_en_o=1. Add overflows when both operands share a sign that the sum lacks. Subtract overflows when the operand signs differ and the difference's sign differs from a_i.
- R3: Functions 0x21 and 0x23 (wrapping subtract) never set ovf_o and always set wr_en_o, even when the signed result overflows.
- R4: Functions 0x22 and 0x23 drive result_o with a_i - b_i modulo 2^32.
- R5: Logic codes are 0x24 AND, 0x25 OR, 0x26 XOR and 0x27 NOR of a_i and b_i. NOR with equal operands gives the bitwise complement.
- R6: Constant shifts shift b_i by shamt_i: 0x00 left, 0x02 logical right (zero fill), 0x03 arithmetic right (sign fill).
- R7: Variable shifts 0x04 left, 0x06 logical right and 0x07 arithmetic right shift b_i by a_i[4:0]. Bits a_i[31:5] have no effect.
- R8: 0x2a (signed) and 0x2b (unsigned) give result_o=1 when a_i < b_i and 0 otherwise, with bits 31..1 zero. For example, a_i=1 and b_i=0xffffffff give 0 signed and 1 unsigned.
- R9: Any other function code gives result_o=0, wr_en_o=0 and ovf_o=0.
- R10: Every recognised code other than an overflowing trapping add or subtract gives wr_en_o=1 and ovf_o=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand; also the amount source for variable shifts |
| b_i | input | 32 | Second operand; the value that is shifted |
| shamt_i | input | 5 | Constant shift amount from the instruction |
| func_i | input | 6 | Function code selecting the operation |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Destination write permitted |
| ovf_o | output | 1 | Arithmetic overflow exception request |

## Verification
The checker enforces relations among the outputs on every input change:
- an overflow flag never coexists with a write enable;
- the wrapping codes and the logic codes never flag overflow;
- a compare never drives bits above bit 0;
- an unknown code yields all zeros.

The arithmetic values can only be shown by the bench scenarios, which compare each result against a wide-integer reference model. These values are the wrapped sums, the overflow boundaries at 0x7fffffff and 0x80000000, the shift fills, the ignored upper amount bits and the disagreement between signed and unsigned compares.

// File: rtl/exec_alu_pkg.sv
package exec_alu_pkg;
  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_SLLV = 6'h04;
  localparam logic [5:0] FN_SRLV = 6'h06;
  localparam logic [5:0] FN_SRAV = 6'h07;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2a;
  localparam logic [5:0] FN_SLTU = 6'h2b;

  typedef enum logic [2:0] {
    U_NONE, U_ARITH, U_LOGIC, U_SHIFT, U_CMP
  } unit_e;

  typedef enum logic [1:0] {
    LG_AND, LG_OR, LG_XOR, LG_NOR
  } logic_op_e;

  typedef struct packed {
    unit_e     unit;
    logic      sub;       // arith: subtract
    logic      trap;      // arith: signed overflow traps
    logic_op_e lop;
    logic      sh_right;
    logic      sh_arith;
    logic      sh_var;    // amount from operand a
    logic      cmp_sgn;
  } dec_t;
endpackage

// File: rtl/exec_alu_decode.sv
module exec_alu_decode
  import exec_alu_pkg::*;
#(
  parameter int FUNC_W = 6
) (
  input  logic [FUNC_W-1:0] func_i,
  output dec_t              dec_o
);
  always_comb begin
    dec_o = '{unit: U_NONE, sub: 1'b0, trap: 1'b0, lop: LG_AND,
              sh_right: 1'b0, sh_arith: 1'b0, sh_var: 1'b0, cmp_sgn: 1'b0};
    case (func_i)
      FN_ADD:  begin dec_o.unit = U_ARITH; dec_o.trap = 1'b1; end
      FN_ADDU: dec_o.unit = U_ARITH;
      FN_SUB:  begin dec_o.unit = U_ARITH; dec_o.sub = 1'b1; dec_o.trap = 1'b1; end
      FN_SUBU: begin dec_o.unit = U_ARITH; dec_o.sub = 1'b1; end
      FN_AND:  begin dec_o.unit = U_LOGIC; dec_o.lop = LG_AND; end
      FN_OR:   begin dec_o.unit = U_LOGIC; dec_o.lop = LG_OR;  end
      FN_XOR:  begin dec_o.unit = U_LOGIC; dec_o.lop = LG_XOR; end
      FN_NOR:  begin dec_o.unit = U_LOGIC; dec_o.lop = LG_NOR; end
      FN_SLL, FN_SRL, FN_SRA, FN_SLLV, FN_SRLV, FN_SRAV: begin
        dec_o.unit     = U_SHIFT;
        dec_o.sh_var   = func_i[2];
        dec_o.sh_right = func_i[1];
        dec_o.sh_arith = func_i[0];
      end
      FN_SLT:  begin dec_o.unit = U_CMP; dec_o.cmp_sgn = 1'b1; end
      FN_SLTU: dec_o.unit = U_CMP;
      default: ;
    endcase
  end
endmodule

// File: rtl/exec_alu_addsub.sv
module exec_alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              sovf_o
);
  localparam int MSB = DATA_W - 1;
  logic [DATA_W-1:0] b_eff;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum_o = a_i + b_eff + {{(DATA_W-1){1'b0}}, sub_i};

  // add: equal operand signs, result sign flipped
  // sub: differing operand signs, result sign differs from a
  always_comb begin
    if (sub_i) sovf_o = (a_i[MSB] != b_i[MSB]) && (sum_o[MSB] != a_i[MSB]);
    else       sovf_o = (a_i[MSB] == b_i[MSB]) && (sum_o[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/exec_alu_shift.sv
module exec_alu_shift #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  val_i,
  input  logic [SHAMT_W-1:0] amt_i,
  input  logic               right_i,
  input  logic               arith_i,
  output logic [DATA_W-1:0]  res_o
);
  logic [DATA_W-1:0] val_rev, out_rev;
  logic [DATA_W-1:0] stg [0:SHAMT_W];
  logic              fill;

  // left shift = right shift of bit-reversed word
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign val_rev[i] = val_i[DATA_W-1-i];
    assign out_rev[i] = stg[SHAMT_W][DATA_W-1-i];
  end

  assign fill   = right_i & arith_i & val_i[DATA_W-1];
  assign stg[0] = right_i ? val_i : val_rev;

  for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stg[s+1] = amt_i[s] ? {{D{fill}}, stg[s][DATA_W-1:D]} : stg[s];
  end

  assign res_o = right_i ? stg[SHAMT_W] : out_rev;
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W),
  parameter int FUNC_W  = 6
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [FUNC_W-1:0]  func_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               wr_en_o,
  output logic               ovf_o
);
  dec_t              dec;
  logic [DATA_W-1:0] sum, sh_res, lg_res;
  logic              sovf, lt;
  logic [SHAMT_W-1:0] amt;

  exec_alu_decode #(.FUNC_W(FUNC_W)) u_dec (.func_i(func_i), .dec_o(dec));

  exec_alu_addsub #(.DATA_W(DATA_W)) u_add (
    .a_i(a_i), .b_i(b_i), .sub_i(dec.sub), .sum_o(sum), .sovf_o(sovf)
  );

  assign amt = dec.sh_var ? a_i[SHAMT_W-1:0] : shamt_i;

  exec_alu_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_sh (
    .val_i(b_i), .amt_i(amt), .right_i(dec.sh_right),
    .arith_i(dec.sh_arith), .res_o(sh_res)
  );

  always_comb begin
    case (dec.lop)
      LG_AND:  lg_res = a_i & b_i;
      LG_OR:   lg_res = a_i | b_i;
      LG_XOR:  lg_res = a_i ^ b_i;
      default: lg_res = ~(a_i | b_i);
    endcase
  end

  assign lt = dec.cmp_sgn ? ($signed(a_i) < $signed(b_i)) : (a_i < b_i);

  always_comb begin
    result_o = '0;
    wr_en_o  = 1'b1;
    ovf_o    = 1'b0;
    case (dec.unit)
      U_ARITH: begin
        result_o = sum;
        ovf_o    = dec.trap & sovf;
        wr_en_o  = ~(dec.trap & sovf);
      end
      U_LOGIC: result_o = lg_res;
      U_SHIFT: result_o = sh_res;
      U_CMP:   result_o = {{(DATA_W-1){1'b0}}, lt};
      default: wr_en_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/exec_alu_chk.sv
module exec_alu_chk #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W),
  parameter int FUNC_W  = 6
) (
  input logic [DATA_W-1:0]  a_i,
  input logic [DATA_W-1:0]  b_i,
  input logic [SHAMT_W-1:0] shamt_i,
  input logic [FUNC_W-1:0]  func_i,
  input logic [DATA_W-1:0]  result_o,
  input logic               wr_en_o,
  input logic               ovf_o
);
  logic known;
  always_comb begin
    case (func_i)
      6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07,
      6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25,
      6'h26, 6'h27, 6'h2a, 6'h2b: known = 1'b1;
      default: known = 1'b0;
    endcase
  end

  always_comb begin
    if (ovf_o)
      a_r2_ovf_blocks_write: assert (!wr_en_o);
    if (func_i == 6'h21 || func_i == 6'h23)
      a_r3_no_overflow: assert (!ovf_o && wr_en_o);
    if (func_i == 6'h2a || func_i == 6'h2b)
      a_r8_cmp_single_bit: assert (result_o[DATA_W-1:1] == '0 && wr_en_o);
    if (!known)
      a_r9_unknown_quiet: assert (result_o == '0 && !wr_en_o && !ovf_o);
    if (known && func_i != 6'h20 && func_i != 6'h22)
      a_r10_write_no_trap: assert (wr_en_o && !ovf_o);
  end

  logic unused_ok;
  assign unused_ok = ^{a_i, b_i, shamt_i};
endmodule

bind exec_alu exec_alu_chk #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .FUNC_W(FUNC_W)) u_chk (
  .a_i(a_i), .b_i(b_i), .shamt_i(shamt_i), .func_i(func_i),
  .result_o(result_o), .wr_en_o(wr_en_o), .ovf_o(ovf_o)
);

// File: tb/exec_alu_tb_top.sv
module exec_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a, b, res;
  logic [4:0]  sh;
  logic [5:0]  fn;
  logic        wr, ov;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  exec_alu dut_i (.a_i(a), .b_i(b), .shamt_i(sh), .func_i(fn),
                  .result_o(res), .wr_en_o(wr), .ovf_o(ov));

  function automatic logic [33:0] model(logic [31:0] x, logic [31:0] y,
                                        logic [4:0] s, logic [5:0] f);
    longint sx = longint'($signed(x));
    longint sy = longint'($signed(y));
    longint w;
    logic [31:0] r = '0;
    logic we = 1'b1, o = 1'b0;
    case (f)
      6'h20, 6'h21: begin
        r = x + y; w = sx + sy;
        if (f == 6'h20 && (w > 64'sd2147483647 || w < -64'sd2147483648)) begin o = 1; we = 0; end
      end
      6'h22, 6'h23: begin
        r = x - y; w = sx - sy;
        if (f == 6'h22 && (w > 64'sd2147483647 || w < -64'sd2147483648)) begin o = 1; we = 0; end
      end
      6'h24: r = x & y;
      6'h25: r = x | y;
      6'h26: r = x ^ y;
      6'h27: r = ~(x | y);
      6'h00: r = y << s;
      6'h02: r = y >> s;
      6'h03: r = $signed(y) >>> s;
      6'h04: r = y << x[4:0];
      6'h06: r = y >> x[4:0];
      6'h07: r = $signed(y) >>> x[4:0];
      6'h2a: r = {31'd0, sx < sy};
      6'h2b: r = {31'd0, x < y};
      default: begin r = '0; we = 0; end
    endcase
    return {r, we, o};
  endfunction

  function automatic string req_of(logic [5:0] f);
    case (f)
      6'h20: return "R1/R2";
      6'h21: return "R1/R3";
      6'h22: return "R4/R2";
      6'h23: return "R4/R3";
      6'h24, 6'h25, 6'h26, 6'h27: return "R5";
      6'h00, 6'h02, 6'h03: return "R6";
      6'h04, 6'h06, 6'h07: return "R7";
      6'h2a, 6'h2b: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic run(input logic [31:0] x, input logic [31:0] y,
                     input logic [4:0] s, input logic [5:0] f, input string tag);
    logic [33:0] e;
    @(negedge clk);
    a = x; b = y; sh = s; fn = f;
    #2;
    e = model(x, y, s, f);
    total++;
    if ({res, wr, ov} !== e) begin
      bad++;
      $display("FAIL %s f=%h a=%h b=%h sh=%0d: got res=%h wr=%b ov=%b exp res=%h wr=%b ov=%b",
               tag, f, x, y, s, res, wr, ov, e[33:2], e[1], e[0]);
    end
  endtask

  task automatic check_val(input logic [31:0] got, input logic [31:0] exp_v, input string tag);
    total++;
    if (got !== exp_v) begin
      bad++;
      $display("FAIL %s: got %h exp %h", tag, got, exp_v);
    end
  endtask

  localparam logic [5:0] CODES [16] = '{6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07,
    6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27, 6'h2a, 6'h2b};

  initial begin
    logic [31:0] tmp;
    void'($urandom(32'h5eed_1234));
    a = '0; b = '0; sh = '0; fn = 6'h21;
    repeat (3) @(posedge clk);
    // reset-time state: wrapping add of zeros (R1, R10)
    run(32'd0, 32'd0, 5'd0, 6'h21, "R10 reset-state");
    rst_ni = 1'b1;

    // R1/R2 add overflow boundaries
    run(32'h7fffffff, 32'h1, 0, 6'h20, "R2 add pos ovf");
    run(32'h80000000, 32'hffffffff, 0, 6'h20, "R2 add neg ovf");
    run(32'h7ffffffe, 32'h1, 0, 6'h20, "R2 add no ovf");
    run(32'h7fffffff, 32'h1, 0, 6'h21, "R3 addu wrap");
    // R4/R2 subtract boundaries
    run(32'h80000000, 32'h1, 0, 6'h22, "R2 sub ovf");
    run(32'h7fffffff, 32'hffffffff, 0, 6'h22, "R2 sub ovf pos");
    run(32'h80000000, 32'h1, 0, 6'h23, "R3 subu wrap");
    run(32'h5, 32'h9, 0, 6'h22, "R4 sub neg result");
    // R5 nor as complement
    run(32'h1234abcd, 32'h1234abcd, 0, 6'h27, "R5 nor not");
    check_val(res, 32'hedcb5432, "R5 nor complement value");
    // R6 shifts
    run(32'h0, 32'habcd1234, 5'd8, 6'h00, "R6 sll");
    run(32'h0, 32'habcd1234, 5'd4, 6'h02, "R6 srl");
    run(32'h0, 32'habcd1234, 5'd31, 6'h03, "R6 sra 31");
    check_val(res, 32'hffffffff, "R6 sra sign fill");
    // R7 variable shifts, upper amount bits ignored
    run(32'hffffffe0 | 32'd16, 32'habcd1234, 5'd3, 6'h07, "R7 srav");
    check_val(res, 32'hffffabcd, "R7 srav upper bits ignored");
    run(32'h00000020, 32'h1, 5'd7, 6'h04, "R7 sllv amount 0");
    check_val(res, 32'h1, "R7 sllv a=32 acts as 0");
    run(32'h00000104, 32'h80000000, 0, 6'h06, "R7 srlv");
    // R8 signed vs unsigned
    run(32'h1, 32'hffffffff, 0, 6'h2a, "R8 slt");
    check_val(res, 32'h0, "R8 slt 1<-1 false");
    run(32'h1, 32'hffffffff, 0, 6'h2b, "R8 sltu");
    check_val(res, 32'h1, "R8 sltu 1<max true");
    run(32'h7, 32'h7, 0, 6'h2a, "R8 equal");
    // R9 unknown codes
    run(32'hffffffff, 32'hffffffff, 5'd31, 6'h3f, "R9 unknown 3f");
    run(32'h1234, 32'h5678, 5'd1, 6'h01, "R9 unknown 01");

    // random mix (R1..R10)
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] f;
      logic [31:0] x, y;
      f = ($urandom % 8 == 0) ? 6'($urandom) : CODES[$urandom % 16];
      x = $urandom; y = $urandom;
      if ($urandom % 4 == 0) x = {x[31], {31{~x[31]}}};
      if ($urandom % 4 == 0) y = {y[31], 31'($urandom % 3)};
      run(x, y, 5'($urandom), f, req_of(f));
    end
    tmp = '0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule